// File: doc/BRIEF.md
# Master-Mode Audio Clock Divider

This block builds the clocks of a master-mode audio serial port from one master clock input. The input runs at a fixed multiple of the sample rate: 256, 512 or 1024 times. A single free-running counter divides it and counts one frame per sample. The block derives three outputs from that counter: a bit clock at 16, 32 or 64 times the sample rate, a frame clock, and, if enabled, a master clock output at 256 times the sample rate.

Each output is a register clocked by the input clock. No clock is gated. Single-cycle strobes mark every rising and falling bit-clock edge and every frame start, so that the serializers beside the block can act on them without a second clock domain. The frame clock follows the chosen format:
- a 50% clock that is low in the first half of the frame for the standard format;
- a 50% clock that is high in the first half for the DSP format;
- a one-bit-period pulse for the DSP format when the short-frame select is set.

The ratio selects and the format selects are meant to be set while reset is held. The master clock output enable may change at any time.

Top module: `audio_clk_gen`

## Requirements
- R1: While `rst` is high at a clock edge, every output (`bclk`, `fclk`, `mclk_out`, `bclk_rise`, `bclk_fall`, `frame_start`) is low after that edge.
- R2: A frame lasts N input-clock cycles, where `mclk_ratio` code 00 gives N=256, 01 gives N=1024, 10 gives N=512 and 11 gives N=256.
- R3: The bit clock period is N/B cycles, where `bclk_ratio` code 00 gives B=16, 01 gives B=32, 10 gives B=64, and the reserved code 11 also gives B=64. The duty cycle is 50%. The bit clock is low in the first half of each bit period, counted from the frame start.
- R4: `bclk_rise` is high for exactly the one cycle in which `bclk` goes from 0 to 1. `bclk_fall` is high for exactly the one cycle in which `bclk` goes from 1 to 0.
- R5: `frame_start` is high for one cycle at the first cycle of each frame. The first frame starts on the first clock edge after `rst` is released. `bclk` is low in that cycle.
- R6: With `fmt_dsp`=0, `fclk` is low for the first N/2 cycles of the frame and high for the last N/2 cycles.
- R7: With `fmt_dsp`=1 and `short_frame`=0, `fclk` is high for the first N/2 cycles and low for the rest of the frame.
- R8: With `fmt_dsp`=1 and `short_frame`=1, `fclk` is high for exactly the first bit period (N/B cycles) of each frame and low for the rest.
- R9: With `fmt_dsp`=0, `short_frame` has no effect on `fclk`.
- R10: When `mclk_out_en` was high before an edge and N is 512 or 1024, `mclk_out` after that edge follows a 50% clock with period N/256 cycles. It is low in the first half of each period, counted from the frame start.
- R11: `mclk_out` is low after any edge at which `mclk_out_en` was low. It is also always low when N is 256, because a registered divider cannot output its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock input, a fixed multiple of the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| mclk_ratio | input | 2 | Input clock ratio code (00:256, 01:1024, 10:512, 11:256) |
| bclk_ratio | input | 2 | Bit clock ratio code (00:16, 01:32, 10/11:64) |
| fmt_dsp | input | 1 | 1 selects the DSP format, 0 the standard format |
| short_frame | input | 1 | In DSP format, 1 selects a one-bit frame pulse |
| mclk_out_en | input | 1 | Enables the 256x master clock output |
| bclk | output | 1 | Bit clock |
| fclk | output | 1 | Frame clock |
| mclk_out | output | 1 | Master clock output, held low when disabled |
| bclk_rise | output | 1 | One-cycle strobe with each bit clock rising edge |
| bclk_fall | output | 1 | One-cycle strobe with each bit clock falling edge |
| frame_start | output | 1 | One-cycle strobe at the first cycle of each frame |

## Verification
The assertions assume that `mclk_ratio`, `bclk_ratio`, `fmt_dsp` and `short_frame` change only while `rst` is high. A change in the middle of a frame would legally move edges away from the frame grid. The stimulus keeps to this rule: every configuration, whether directed or drawn from the seeded generator, is applied at a reset, and only `mclk_out_en` is toggled while the clocks run. The enable is toggled between bench-sampled edges, so its one-edge latency can be predicted exactly.

// File: rtl/acg_pkg.sv
package acg_pkg;

  localparam int LOG_W = 4;

  typedef enum logic [1:0] {
    MR_256_A = 2'b00,
    MR_1024  = 2'b01,
    MR_512   = 2'b10,
    MR_256_B = 2'b11
  } mclk_ratio_e;

  typedef enum logic [1:0] {
    BR_16     = 2'b00,
    BR_32     = 2'b01,
    BR_64     = 2'b10,
    BR_64_RSV = 2'b11
  } bclk_ratio_e;

  // log2 of input cycles per frame
  function automatic logic [LOG_W-1:0] mclk_log2(input logic [1:0] code);
    case (code)
      MR_1024: mclk_log2 = 4'd10;
      MR_512:  mclk_log2 = 4'd9;
      default: mclk_log2 = 4'd8;
    endcase
  endfunction

  // log2 of bit clocks per frame; reserved code acts as 64x
  function automatic logic [LOG_W-1:0] bclk_log2(input logic [1:0] code);
    case (code)
      BR_16:   bclk_log2 = 4'd4;
      BR_32:   bclk_log2 = 4'd5;
      default: bclk_log2 = 4'd6;
    endcase
  endfunction

endpackage

// File: rtl/acg_timebase.sv
module acg_timebase
  import acg_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LOG_W-1:0] frame_lg,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             frame_start
);

  localparam logic [LOG_W-1:0] CW = LOG_W'(CNT_W);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last    = {CNT_W{1'b1}} >> (CW - frame_lg);
  // reset value is all ones, so the first edge out of reset wraps to zero
  assign cnt_nxt = (cnt_q >= last) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q       <= '1;
      frame_start <= 1'b0;
    end else begin
      cnt_q       <= cnt_nxt;
      frame_start <= (cnt_nxt == '0);
    end
  end

  // R2: once running, the count stays inside the selected frame length
  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (cnt_q <= last));

endmodule

// File: rtl/acg_bitclk.sv
module acg_bitclk
  import acg_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [LOG_W-1:0] half_idx,
  output logic             bclk,
  output logic             bclk_rise,
  output logic             bclk_fall
);

  logic b_nxt;

  assign b_nxt = |(cnt_nxt & (CNT_W'(1) << half_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk      <= 1'b0;
      bclk_rise <= 1'b0;
      bclk_fall <= 1'b0;
    end else begin
      bclk      <= b_nxt;
      bclk_rise <= b_nxt & ~bclk;
      bclk_fall <= ~b_nxt & bclk;
    end
  end

  // R4: strobes mark real transitions of the bit clock output
  a_r4_rise_edge: assert property (@(posedge clk) disable iff (rst)
    bclk_rise |-> (bclk && !$past(bclk)));
  a_r4_fall_edge: assert property (@(posedge clk) disable iff (rst)
    bclk_fall |-> (!bclk && $past(bclk)));
  a_r4_no_silent_toggle: assert property (@(posedge clk) disable iff (rst)
    (bclk != $past(bclk)) |-> (bclk_rise || bclk_fall));

endmodule

// File: rtl/acg_frameclk.sv
module acg_frameclk
  import acg_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [LOG_W-1:0] frame_lg,
  input  logic [LOG_W-1:0] bitper_lg,
  input  logic             fmt_dsp,
  input  logic             short_frame,
  output logic             fclk
);

  logic second_half;
  logic first_bit;
  logic f_nxt;

  assign second_half = |(cnt_nxt & (CNT_W'(1) << (frame_lg - 4'd1)));
  assign first_bit   = ((cnt_nxt >> bitper_lg) == '0);

  always_comb begin
    if (!fmt_dsp)         f_nxt = second_half;
    else if (short_frame) f_nxt = first_bit;
    else                  f_nxt = ~second_half;
  end

  always_ff @(posedge clk) begin
    if (rst) fclk <= 1'b0;
    else     fclk <= f_nxt;
  end

endmodule

// File: rtl/acg_mclkout.sv
module acg_mclkout
  import acg_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int MCO_LOG2 = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [LOG_W-1:0] frame_lg,
  input  logic             enable,
  output logic             mclk_out
);

  localparam logic [LOG_W-1:0] MCO_LG = LOG_W'(MCO_LOG2);

  logic             avail;
  logic [LOG_W-1:0] idx;
  logic             m_nxt;

  assign avail = (frame_lg > MCO_LG);
  assign idx   = frame_lg - MCO_LG - 4'd1;
  assign m_nxt = enable & avail & (|(cnt_nxt & (CNT_W'(1) << idx)));

  always_ff @(posedge clk) begin
    if (rst) mclk_out <= 1'b0;
    else     mclk_out <= m_nxt;
  end

  // R11: a low enable before an edge leaves the output low after it
  a_r11_off_when_disabled: assert property (@(posedge clk) disable iff (rst)
    !$past(enable) |-> !mclk_out);

endmodule

// File: rtl/audio_clk_gen.sv
module audio_clk_gen
  import acg_pkg::*;
#(
  parameter int CNT_W        = 10,
  parameter int MCO_LOG2     = 8,
  parameter bit HAS_MCLK_OUT = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mclk_ratio,
  input  logic [1:0] bclk_ratio,
  input  logic       fmt_dsp,
  input  logic       short_frame,
  input  logic       mclk_out_en,
  output logic       bclk,
  output logic       fclk,
  output logic       mclk_out,
  output logic       bclk_rise,
  output logic       bclk_fall,
  output logic       frame_start
);

  logic [LOG_W-1:0] frame_lg;
  logic [LOG_W-1:0] bits_lg;
  logic [LOG_W-1:0] bitper_lg;
  logic [LOG_W-1:0] half_idx;
  logic [CNT_W-1:0] cnt_nxt;

  assign frame_lg  = mclk_log2(mclk_ratio);
  assign bits_lg   = bclk_log2(bclk_ratio);
  assign bitper_lg = frame_lg - bits_lg;
  assign half_idx  = bitper_lg - 4'd1;

  acg_timebase #(.CNT_W(CNT_W)) u_timebase (
    .clk         (clk),
    .rst         (rst),
    .frame_lg    (frame_lg),
    .cnt_nxt     (cnt_nxt),
    .frame_start (frame_start)
  );

  acg_bitclk #(.CNT_W(CNT_W)) u_bitclk (
    .clk       (clk),
    .rst       (rst),
    .cnt_nxt   (cnt_nxt),
    .half_idx  (half_idx),
    .bclk      (bclk),
    .bclk_rise (bclk_rise),
    .bclk_fall (bclk_fall)
  );

  acg_frameclk #(.CNT_W(CNT_W)) u_frameclk (
    .clk         (clk),
    .rst         (rst),
    .cnt_nxt     (cnt_nxt),
    .frame_lg    (frame_lg),
    .bitper_lg   (bitper_lg),
    .fmt_dsp     (fmt_dsp),
    .short_frame (short_frame),
    .fclk        (fclk)
  );

  generate
    if (HAS_MCLK_OUT) begin : g_mco
      acg_mclkout #(.CNT_W(CNT_W), .MCO_LOG2(MCO_LOG2)) u_mclkout (
        .clk      (clk),
        .rst      (rst),
        .cnt_nxt  (cnt_nxt),
        .frame_lg (frame_lg),
        .enable   (mclk_out_en),
        .mclk_out (mclk_out)
      );
    end else begin : g_no_mco
      assign mclk_out = 1'b0;
    end
  endgenerate

  // R5: frames begin while the bit clock is low
  a_r5_start_bclk_low: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> !bclk);
  // R6: standard format starts each frame with the frame clock low
  a_r6_start_low: assert property (@(posedge clk) disable iff (rst)
    (frame_start && !fmt_dsp) |-> !fclk);
  // R7: DSP format starts each frame with the frame clock high
  a_r7_start_high: assert property (@(posedge clk) disable iff (rst)
    (frame_start && fmt_dsp) |-> fclk);
  // R8: the short pulse only rises at a frame start
  a_r8_pulse_at_start: assert property (@(posedge clk) disable iff (rst)
    (fmt_dsp && short_frame && $rose(fclk)) |-> frame_start);
  // R11: no master clock output at the 256x input ratio
  a_r11_off_at_256: assert property (@(posedge clk) disable iff (rst)
    (mclk_ratio == MR_256_A || mclk_ratio == MR_256_B) |-> !mclk_out);

endmodule

// File: tb/test_audio_clk_gen.sv
`timescale 1ns/1ps
module test_audio_clk_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mclk_ratio = 2'b00;
  logic [1:0] bclk_ratio = 2'b00;
  logic       fmt_dsp = 1'b0;
  logic       short_frame = 1'b0;
  logic       mclk_out_en = 1'b0;
  logic       bclk, fclk, mclk_out, bclk_rise, bclk_fall, frame_start;

  int checks = 0;
  int errors = 0;
  int step = 0;

  always #2.5 clk = ~clk;

  audio_clk_gen i_audio_clk_gen (
    .clk         (clk),
    .rst         (rst),
    .mclk_ratio  (mclk_ratio),
    .bclk_ratio  (bclk_ratio),
    .fmt_dsp     (fmt_dsp),
    .short_frame (short_frame),
    .mclk_out_en (mclk_out_en),
    .bclk        (bclk),
    .fclk        (fclk),
    .mclk_out    (mclk_out),
    .bclk_rise   (bclk_rise),
    .bclk_fall   (bclk_fall),
    .frame_start (frame_start)
  );

  function automatic int frame_len(input logic [1:0] code);
    case (code)
      2'b01:   return 1024;
      2'b10:   return 512;
      default: return 256;
    endcase
  endfunction

  function automatic int bits_per_frame(input logic [1:0] code);
    case (code)
      2'b00:   return 16;
      2'b01:   return 32;
      default: return 64;
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s step %0d actual=%0b expected=%0b", tag, step, act, exp);
    end
  endtask

  task automatic run_cfg(input logic [1:0] mr, input logic [1:0] br,
                         input logic dsp, input logic pul,
                         input logic en0, input bit toggle_en);
    int   n, p, steps, c, q;
    logic bprev, en_used, bx, fx, mx;
    string ftag;
    @(negedge clk);
    rst = 1'b1;
    mclk_ratio = mr; bclk_ratio = br; fmt_dsp = dsp; short_frame = pul;
    mclk_out_en = en0;
    repeat (3) @(negedge clk);
    step = 0;
    // R1: reset state on every output
    check("R1 bclk", bclk, 1'b0);
    check("R1 fclk", fclk, 1'b0);
    check("R1 mclk_out", mclk_out, 1'b0);
    check("R1 bclk_rise", bclk_rise, 1'b0);
    check("R1 bclk_fall", bclk_fall, 1'b0);
    check("R1 frame_start", frame_start, 1'b0);
    rst = 1'b0;
    en_used = mclk_out_en;
    n = frame_len(mr);
    p = n / bits_per_frame(br);
    q = n / 256;
    steps = 2 * n + 8;
    bprev = 1'b0;
    if (!dsp) ftag = pul ? "R9 fclk" : "R6 fclk";
    else      ftag = pul ? "R8 fclk" : "R7 fclk";
    for (int j = 1; j <= steps; j++) begin
      @(negedge clk);
      step = j;
      c  = (j - 1) % n;
      bx = ((c % p) >= (p / 2));
      if (!dsp)     fx = (c >= n / 2);
      else if (pul) fx = (c < p);
      else          fx = (c < n / 2);
      mx = en_used && (n > 256) && ((c % q) >= (q / 2));
      check("R3 bclk", bclk, bx);
      check("R4 bclk_rise", bclk_rise, bx && !bprev);
      check("R4 bclk_fall", bclk_fall, !bx && bprev);
      check("R2,R5 frame_start", frame_start, c == 0);
      check(ftag, fclk, fx);
      if (en_used && n > 256) check("R10 mclk_out", mclk_out, mx);
      else                    check("R11 mclk_out", mclk_out, 1'b0);
      bprev = bx;
      if (toggle_en && (j % 97 == 0)) mclk_out_en = ~mclk_out_en;
      en_used = mclk_out_en;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog step %0d actual=timeout expected=done", step);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed_val;
    seed_val = $urandom(32'd4711);
    // directed corner cases
    run_cfg(2'b00, 2'b10, 1'b1, 1'b1, 1'b1, 1'b1); // R8 at smallest bit period, R11 at 256x
    run_cfg(2'b01, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1); // R2 1024x, R6, R10 toggling
    run_cfg(2'b10, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0); // R7, R10 at 512x
    run_cfg(2'b11, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0); // R2 code 11, R3 reserved code
    run_cfg(2'b01, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0); // R11 disabled at 1024x
    run_cfg(2'b10, 2'b11, 1'b0, 1'b1, 1'b1, 1'b1); // R9 pulse select ignored
    run_cfg(2'b00, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1); // R9 at 256x, 16x bits
    // seeded random configurations
    for (int k = 0; k < 8; k++) begin
      logic [3:0] r;
      r = 4'($urandom);
      run_cfg(2'($urandom), 2'($urandom), r[0], r[1], r[2], r[3]);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule